// File: doc/BRIEF.md
# Reset Cause Recorder and Boot Clock Selector

This block sits beside the processor core of a small microcontroller. It collects every request that restarts the chip: power-on, brown-out, the external reset pin, a software reset instruction, a watchdog expiry, a trap conflict and an illegal-opcode event. Each cause leaves a sticky bit in a 16-bit cause register. Entry to sleep or idle also leaves a sticky bit. Firmware reads this register after boot to learn why it restarted, and it may rewrite the register at any time.

The block drives the system reset. That reset is held until two delay timers outside the block have both reported expiry. A separate clock-ready condition waits for the oscillator start-up timer and the PLL lock. The core may run only when the reset is released and the clock is ready. Once the core runs, the clock-fail monitor is enabled.

The block also chooses the 3-bit clock-source code that the core uses after each reset. A supply-related reset takes the configured source. Any other reset keeps the oscillator that is running at that moment, unless clock switching is disabled.

Top module: `rst_cause_clk_mgr`

## Requirements
- R1: While `rst_n` is low, `flags` reads 0x0003, `sys_rst` is 1, `cpu_run` is 0, `fscm_en` is 0 and `clk_src` is 0.
- R2: One cycle after a pulse, each event sets its own flag bit, and that bit stays set. The bit positions are: trap conflict 15, illegal opcode 14, external pin 7, software reset 6, watchdog 4, sleep entry 3, idle entry 2. Several events in one cycle set all of their bits.
- R3: A power-on event sets bits 1 and 0 and clears every other bit. A brown-out event sets bit 1, clears bits 15..2 and leaves bit 0 as it was. Power-on takes precedence over brown-out.
- R4: With `wr_en` high, `wr_data` is loaded into the implemented bits 15, 14, 7, 6, 4, 3, 2, 1 and 0. Bits 13..8 and bit 5 always read 0, so writing 0xFFFF reads back 0xC0DF.
- R5: When a write and a hardware set event fall in the same cycle, the hardware-set bit ends up 1, whatever value was written.
- R6: `clk_src` is loaded in these cases:
  - from `cfg_osc` on power-on, on brown-out, in the first cycle after `rst_n` rises, and on any reset while `csw_en` is 0;
  - from `cur_osc` on an external, software, watchdog, trap-conflict or illegal-opcode reset while `csw_en` is 1.

  `clk_src` does not change in any other cycle, including sleep or idle entry.
- R7: `sys_rst` goes to 1 one cycle after any of the seven reset events, and also after `rst_n` is released. Sleep and idle entry do not assert it. `sys_rst` returns to 0 one cycle after both `por_dly_done` and `pwrt_done` have pulsed, in either order. A pulse that arrives in the same cycle as a reset event does not count.
- R8: `cpu_run` is 1 exactly when `sys_rst` is 0 and both `ost_done` and `pll_lock` have pulsed since the last power-on or brown-out reset, or since `rst_n`. The other reset types leave this clock-ready state unchanged.
- R9: `fscm_en` rises one cycle after `cpu_run` rises. It is 0 in the cycle after any reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, treated as a power-on |
| por_evt | input | 1 | Power-on reset pulse |
| bor_evt | input | 1 | Brown-out reset pulse |
| ext_evt | input | 1 | External reset pin pulse |
| swr_evt | input | 1 | Software reset instruction pulse |
| wdt_evt | input | 1 | Watchdog time-out pulse |
| trap_evt | input | 1 | Trap conflict pulse |
| iop_evt | input | 1 | Illegal opcode or uninitialized register access pulse |
| sleep_evt | input | 1 | Sleep entry pulse |
| idle_evt | input | 1 | Idle entry pulse |
| por_dly_done | input | 1 | Power-on delay expired strobe |
| pwrt_done | input | 1 | Power-up timer expired strobe |
| ost_done | input | 1 | Oscillator start-up timer expired strobe |
| pll_lock | input | 1 | PLL lock strobe |
| csw_en | input | 1 | Clock switching enabled |
| cfg_osc | input | 3 | Configured oscillator source |
| cur_osc | input | 3 | Currently active oscillator source |
| wr_en | input | 1 | Cause register write strobe |
| wr_data | input | 16 | Cause register write value |
| sys_rst | output | 1 | System reset, active high |
| cpu_run | output | 1 | Core may execute |
| fscm_en | output | 1 | Clock-fail monitor enable |
| flags | output | 16 | Reset cause register |
| clk_src | output | 3 | Clock-source code chosen at reset |

## Verification
A vector table applies each event on its own and one pair of events together. Before each vector the register is cleared, so each vector shows that exactly one bit position responds and that no other bit moves. Each vector uses different `cfg_osc` and `cur_osc` codes, which shows from the `clk_src` value which of the two fields was loaded: supply resets load one, other resets load the other, and a disabled clock switch overrides the choice. Directed cases then cover the remaining orderings:
- the two delay strobes arriving apart, and arriving together with the reset event;
- a brown-out with the power-on bit both set and clear beforehand;
- a write colliding with a hardware set;
- the clock-ready strobes arriving after release.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  localparam int FLAG_W = 16;
  localparam int OSC_W  = 3;

  // bit positions are decoded by firmware and must not move
  localparam int B_TRAP = 15;
  localparam int B_IOP  = 14;
  localparam int B_EXT  = 7;
  localparam int B_SWR  = 6;
  localparam int B_WDT  = 4;
  localparam int B_SLP  = 3;
  localparam int B_IDL  = 2;
  localparam int B_BOR  = 1;
  localparam int B_POR  = 0;

  localparam logic [FLAG_W-1:0] ONE      = FLAG_W'(1);
  localparam logic [FLAG_W-1:0] POR_VAL  = (ONE << B_POR) | (ONE << B_BOR);
  localparam logic [FLAG_W-1:0] IMPL_MSK = (ONE << B_TRAP) | (ONE << B_IOP) |
                                           (ONE << B_EXT)  | (ONE << B_SWR) |
                                           (ONE << B_WDT)  | (ONE << B_SLP) |
                                           (ONE << B_IDL)  | POR_VAL;

  typedef struct packed {
    logic por;
    logic bor;
    logic ext;
    logic swr;
    logic wdt;
    logic trap;
    logic iop;
    logic slp;
    logic idl;
  } rcm_evt_t;
endpackage

// File: rtl/rcm_flags.sv
module rcm_flags
  import rcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rcm_evt_t          evt_i,
  input  logic              wr_en_i,
  input  logic [FLAG_W-1:0] wr_data_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] flags_q, flags_d, hw_set, base;
  logic              upd_en;

  always_comb begin
    hw_set         = '0;
    hw_set[B_TRAP] = evt_i.trap;
    hw_set[B_IOP]  = evt_i.iop;
    hw_set[B_EXT]  = evt_i.ext;
    hw_set[B_SWR]  = evt_i.swr;
    hw_set[B_WDT]  = evt_i.wdt;
    hw_set[B_SLP]  = evt_i.slp;
    hw_set[B_IDL]  = evt_i.idl;
    base    = wr_en_i ? (wr_data_i & IMPL_MSK) : flags_q;
    flags_d = base | hw_set;               // hardware set beats the write
    if (evt_i.por)      flags_d = POR_VAL;
    else if (evt_i.bor) flags_d = (flags_q & (ONE << B_POR)) | (ONE << B_BOR);
    upd_en = wr_en_i | (|evt_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= POR_VAL;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  AST_HWSET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.trap && !evt_i.por && !evt_i.bor) |=> flags_o[B_TRAP]); // R5
  AST_POR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.por |=> (flags_o == POR_VAL)); // R3
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !(|evt_i)) |=> $stable(flags_o)); // R2
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ((flags_o & ~IMPL_MSK) == '0)); // R4
endmodule

// File: rtl/rcm_clksel.sv
module rcm_clksel #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_rst_i,
  input  logic         any_rst_i,
  input  logic         csw_en_i,
  input  logic [W-1:0] cfg_osc_i,
  input  logic [W-1:0] cur_osc_i,
  output logic [W-1:0] src_o
);
  logic [W-1:0] src_q, src_d;

  always_comb begin
    src_d = (pwr_rst_i || !csw_en_i) ? cfg_osc_i : cur_osc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         src_q <= '0;
    else if (any_rst_i) src_q <= src_d;
  end

  assign src_o = src_q;

  AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !any_rst_i |=> $stable(src_o)); // R6
  AST_SRC_NOSWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (any_rst_i && !csw_en_i) |=> (src_o == $past(cfg_osc_i))); // R6
endmodule

// File: rtl/rcm_gate.sv
module rcm_gate #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  logic [N-1:0] done_i,
  output logic         ready_o
);
  logic [N-1:0] seen_q, seen_d;
  logic         ready_q, ready_d;

  for (genvar g = 0; g < N; g++) begin : g_seen
    always_comb seen_d[g] = restart_i ? 1'b0 : (seen_q[g] | done_i[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q[g] <= 1'b0;
      else        seen_q[g] <= seen_d[g];
    end
  end

  always_comb ready_d = !restart_i && (&(seen_q | done_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  assign ready_o = ready_q;

  AST_GATE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !ready_o); // R7 R8
  AST_GATE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !restart_i) |=> ready_o); // R8
endmodule

// File: rtl/rst_cause_clk_mgr.sv
module rst_cause_clk_mgr
  import rcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_evt,
  input  logic              bor_evt,
  input  logic              ext_evt,
  input  logic              swr_evt,
  input  logic              wdt_evt,
  input  logic              trap_evt,
  input  logic              iop_evt,
  input  logic              sleep_evt,
  input  logic              idle_evt,
  input  logic              por_dly_done,
  input  logic              pwrt_done,
  input  logic              ost_done,
  input  logic              pll_lock,
  input  logic              csw_en,
  input  logic [OSC_W-1:0]  cfg_osc,
  input  logic [OSC_W-1:0]  cur_osc,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  output logic              sys_rst,
  output logic              cpu_run,
  output logic              fscm_en,
  output logic [FLAG_W-1:0] flags,
  output logic [OSC_W-1:0]  clk_src
);
  logic     boot_q;
  logic     por_i, pwr_rst, any_rst;
  logic     sys_ready, clk_ready;
  logic     fscm_q, fscm_d;
  rcm_evt_t evt;

  // first cycle after rst_n behaves as a power-on event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end

  always_comb begin
    por_i    = por_evt | boot_q;
    pwr_rst  = por_i | bor_evt;
    any_rst  = pwr_rst | ext_evt | swr_evt | wdt_evt | trap_evt | iop_evt;
    evt.por  = por_i;
    evt.bor  = bor_evt;
    evt.ext  = ext_evt;
    evt.swr  = swr_evt;
    evt.wdt  = wdt_evt;
    evt.trap = trap_evt;
    evt.iop  = iop_evt;
    evt.slp  = sleep_evt;
    evt.idl  = idle_evt;
  end

  rcm_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .flags_o   (flags)
  );

  rcm_clksel #(.W(OSC_W)) u_clksel (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_rst_i (pwr_rst),
    .any_rst_i (any_rst),
    .csw_en_i  (csw_en),
    .cfg_osc_i (cfg_osc),
    .cur_osc_i (cur_osc),
    .src_o     (clk_src)
  );

  rcm_gate #(.N(2)) u_sys_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (any_rst),
    .done_i    ({pwrt_done, por_dly_done}),
    .ready_o   (sys_ready)
  );

  rcm_gate #(.N(2)) u_clk_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (pwr_rst),
    .done_i    ({pll_lock, ost_done}),
    .ready_o   (clk_ready)
  );

  always_comb begin
    sys_rst = !sys_ready;
    cpu_run = sys_ready & clk_ready;
    fscm_d  = !any_rst & cpu_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fscm_q <= 1'b0;
    else        fscm_q <= fscm_d;
  end

  assign fscm_en = fscm_q;

  AST_FSCM_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    fscm_en |-> $past(cpu_run)); // R9
  AST_FSCM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    any_rst |=> !fscm_en); // R9
  AST_PWRSAVE_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    ((sleep_evt || idle_evt) && !any_rst && !sys_rst) |=> !sys_rst); // R7
  AST_RST_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    any_rst |=> (sys_rst && !cpu_run)); // R7
endmodule

// File: tb/rst_cause_clk_mgr_tb.sv
module rst_cause_clk_mgr_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        por_evt, bor_evt, ext_evt, swr_evt, wdt_evt, trap_evt, iop_evt;
  logic        sleep_evt, idle_evt;
  logic        por_dly_done, pwrt_done, ost_done, pll_lock, csw_en;
  logic [2:0]  cfg_osc, cur_osc;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        sys_rst, cpu_run, fscm_en;
  logic [15:0] flags;
  logic [2:0]  clk_src;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  rst_cause_clk_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .bor_evt(bor_evt),
    .ext_evt(ext_evt), .swr_evt(swr_evt), .wdt_evt(wdt_evt),
    .trap_evt(trap_evt), .iop_evt(iop_evt), .sleep_evt(sleep_evt),
    .idle_evt(idle_evt), .por_dly_done(por_dly_done), .pwrt_done(pwrt_done),
    .ost_done(ost_done), .pll_lock(pll_lock), .csw_en(csw_en),
    .cfg_osc(cfg_osc), .cur_osc(cur_osc), .wr_en(wr_en), .wr_data(wr_data),
    .sys_rst(sys_rst), .cpu_run(cpu_run), .fscm_en(fscm_en),
    .flags(flags), .clk_src(clk_src)
  );

  // {evt[8:0] por,bor,ext,swr,wdt,trap,iop,slp,idl | csw | cfg | cur | flags | src | rst}
  localparam int NV = 11;
  localparam logic [35:0] VEC [NV] = '{
    {9'h040, 1'b1, 3'd1, 3'd5, 16'h0080, 3'd5, 1'b1},
    {9'h020, 1'b1, 3'd2, 3'd6, 16'h0040, 3'd6, 1'b1},
    {9'h010, 1'b1, 3'd3, 3'd4, 16'h0010, 3'd4, 1'b1},
    {9'h008, 1'b1, 3'd0, 3'd7, 16'h8000, 3'd7, 1'b1},
    {9'h004, 1'b1, 3'd0, 3'd3, 16'h4000, 3'd3, 1'b1},
    {9'h002, 1'b1, 3'd6, 3'd1, 16'h0008, 3'd3, 1'b0},
    {9'h001, 1'b1, 3'd6, 3'd1, 16'h0004, 3'd3, 1'b0},
    {9'h080, 1'b1, 3'd2, 3'd7, 16'h0002, 3'd2, 1'b1},
    {9'h100, 1'b1, 3'd5, 3'd1, 16'h0003, 3'd5, 1'b1},
    {9'h040, 1'b0, 3'd4, 3'd1, 16'h0080, 3'd4, 1'b1},
    {9'h050, 1'b1, 3'd6, 3'd2, 16'h0090, 3'd2, 1'b1}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_evt(input logic [8:0] e);
    {por_evt, bor_evt, ext_evt, swr_evt, wdt_evt, trap_evt, iop_evt, sleep_evt, idle_evt} = e;
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic release_all();
    por_dly_done = 1'b1; pwrt_done = 1'b1; ost_done = 1'b1; pll_lock = 1'b1;
    step();
    por_dly_done = 1'b0; pwrt_done = 1'b0; ost_done = 1'b0; pll_lock = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; set_evt('0); por_dly_done = 0; pwrt_done = 0; ost_done = 0;
    pll_lock = 0; csw_en = 1'b1; cfg_osc = 3'd6; cur_osc = 3'd2;
    wr_en = 0; wr_data = '0;
    repeat (3) step();
    chk("R1 flags", flags, 16'h0003);
    chk("R1 sys_rst", 16'(sys_rst), 16'd1);
    chk("R1 cpu_run", 16'(cpu_run), 16'd0);
    chk("R1 fscm_en", 16'(fscm_en), 16'd0);
    chk("R1 clk_src", 16'(clk_src), 16'd0);
    rst_n = 1'b1;
    step();
    chk("R6 boot loads cfg", 16'(clk_src), 16'd6);

    // R8: reset released but clock not ready
    por_dly_done = 1; pwrt_done = 1; step(); por_dly_done = 0; pwrt_done = 0;
    chk("R7 released", 16'(sys_rst), 16'd0);
    chk("R8 no clock yet", 16'(cpu_run), 16'd0);
    ost_done = 1; step(); ost_done = 0;
    chk("R8 ost only", 16'(cpu_run), 16'd0);
    pll_lock = 1; step(); pll_lock = 0;
    chk("R8 clock ready", 16'(cpu_run), 16'd1);
    chk("R9 fscm lags", 16'(fscm_en), 16'd0);
    step();
    chk("R9 fscm on", 16'(fscm_en), 16'd1);

    // R4 write masking
    wr(16'hFFFF);
    chk("R4 write all ones", flags, 16'hC0DF);
    wr(16'h0000);
    chk("R4 write zero", flags, 16'h0000);

    // R5 collision; R8 non-supply reset keeps clock ready
    wr_en = 1; wr_data = 16'h0000; wdt_evt = 1; step(); wr_en = 0; wdt_evt = 0;
    chk("R5 hw set wins", flags, 16'h0010);
    chk("R9 fscm drops", 16'(fscm_en), 16'd0);
    por_dly_done = 1; pwrt_done = 1; step(); por_dly_done = 0; pwrt_done = 0;
    chk("R8 clock ready kept", 16'(cpu_run), 16'd1);

    // R7 ordering and same-cycle strobes
    ext_evt = 1; por_dly_done = 1; pwrt_done = 1; step();
    ext_evt = 0; por_dly_done = 0; pwrt_done = 0;
    chk("R7 same-cycle strobe ignored", 16'(sys_rst), 16'd1);
    pwrt_done = 1; step(); pwrt_done = 0;
    chk("R7 one strobe only", 16'(sys_rst), 16'd1);
    por_dly_done = 1; step(); por_dly_done = 0;
    chk("R7 both strobes", 16'(sys_rst), 16'd0);

    // R3 brown-out keeps bit 0
    wr(16'h0081);
    bor_evt = 1; step(); bor_evt = 0;
    chk("R3 bor keeps por bit", flags, 16'h0003);
    release_all();
    wr(16'h0080);
    bor_evt = 1; step(); bor_evt = 0;
    chk("R3 bor clears others", flags, 16'h0002);
    release_all();

    // vector table: R2 R3 R6 R7
    for (int i = 0; i < NV; i++) begin
      wr(16'h0000);
      csw_en = VEC[i][26]; cfg_osc = VEC[i][25:23]; cur_osc = VEC[i][22:20];
      set_evt(VEC[i][35:27]);
      step();
      set_evt('0);
      chk($sformatf("R2/R3 vec%0d flags", i), flags, VEC[i][19:4]);
      chk($sformatf("R6 vec%0d clk_src", i), 16'(clk_src), 16'(VEC[i][3:1]));
      chk($sformatf("R7 vec%0d sys_rst", i), 16'(sys_rst), 16'(VEC[i][0]));
      if (VEC[i][0]) begin
        release_all();
        chk($sformatf("R7 vec%0d release", i), 16'(sys_rst), 16'd0);
      end
    end
    csw_en = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule